// File: doc/BRIEF.md
# Four-Bank Byte-Writable Register File

This block stores 127 registers of 64 bits each in four independent 32-bit banks. Each register is placed by the parity of its number and then split into a low half and a high half. Two registers of opposite parity can therefore be written in full in the same cycle. Four 32-bit halves can also be written in the same cycle, provided each falls into a different bank. Each bank has one write port with byte enables, so an 8-bit or 16-bit update never needs a read-modify-write. Each bank also has two combinational read ports.

A read that addresses the entry being written in the same cycle sees the new data. The bypass works byte by byte: enabled bytes come from the write data and the other bytes come from storage. The register file can therefore act as a same-cycle forwarding path. Ports are addressed per bank by the index within the bank, which is the register number shifted right by one.

Top module: `banked_regfile`

## Requirements
- R1: After the asynchronous active-low reset, every entry of every bank reads as zero.
- R2: Bank b holds register parity b[1] (0 even, 1 odd) and half b[0] (0 for bits 31:0, 1 for bits 63:32). Register n lives at index n>>1. A 64-bit register is read or written by driving both halves of its parity at the same index.
- R3: On the rising edge of a write, byte enable bit k of a bank replaces only bits 8k+7:8k of the addressed entry. All other bytes keep their value.
- R4: All four banks accept a write in the same cycle, and no write affects another bank.
- R5: Each bank's two read ports are combinational and independent. Each returns the stored entry at its own index.
- R6: When a read index equals the index of an active in-range write to the same bank in the same cycle, each byte whose enable is set shows the write data. Each byte whose enable is clear shows storage.
- R7: With the write enable low, the byte enables and write data have no effect on storage or on any read.
- R8: An index at or beyond a bank's depth (the odd banks hold 63 entries, so index 63 there is register 127) drops writes and reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 4x2x6 | Read index per bank and per read port |
| rd_data_o | output | 4x2x32 | Read data per bank and per read port |
| wr_en_i | input | 4 | Write enable per bank |
| wr_idx_i | input | 4x6 | Write index per bank |
| wr_data_i | input | 4x32 | Write data per bank |
| wr_be_i | input | 4x4 | Byte enables per bank |

## Verification
Read data is due in the same cycle as its index, with the same-cycle write bypass included. A write becomes visible from storage only after the next rising edge. The bench drives inputs on the falling edge and samples each read output one time unit later, before the rising edge. At that point it checks every port against a byte-level model that merges any pending write. Only after the edge does it fold that write into the model, so the next cycle's expectation already includes the stored bytes. The directed cases use fixed constants rather than the model to pin down the bank numbering, partial byte writes, the disabled write and the out-of-range index.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int WORD_W    = 32;
  localparam int BE_W      = WORD_W / 8;
  localparam int NUM_BANKS = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BE_W-1:0]   be_t;

  // bank number = {parity, half}
  typedef enum logic [1:0] {
    BANK_EVEN_LO = 2'd0,
    BANK_EVEN_HI = 2'd1,
    BANK_ODD_LO  = 2'd2,
    BANK_ODD_HI  = 2'd3
  } bank_e;

  function automatic word_t byte_merge(word_t old_w, word_t new_w, be_t be);
    word_t r;
    for (int k = 0; k < BE_W; k++)
      r[8*k +: 8] = be[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
    return r;
  endfunction

  function automatic int bank_depth(int num_regs, int bank);
    return (bank >= 2) ? num_regs / 2 : (num_regs + 1) / 2;
  endfunction
endpackage

// File: rtl/rf_fwd.sv
module rf_fwd
  import rf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  word_t            raw_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_hit_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  word_t            wr_data_i,
  input  be_t              wr_be_i,
  output word_t            data_o
);
  logic match;
  assign match  = wr_hit_i && (wr_idx_i == rd_idx_i);
  assign data_o = match ? byte_merge(raw_i, wr_data_i, wr_be_i) : raw_i;
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int IDX_W    = 6,
  parameter int RD_PORTS = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [RD_PORTS-1:0][IDX_W-1:0] rd_idx_i,
  output word_t [RD_PORTS-1:0]           rd_data_o,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  word_t                          wr_data_i,
  input  be_t                            wr_be_i
);
  localparam logic [IDX_W:0] DEPTH_L = DEPTH[IDX_W:0];

  word_t mem_q [DEPTH];
  logic  wr_hit;

  assign wr_hit = wr_en_i && ({1'b0, wr_idx_i} < DEPTH_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (wr_hit) begin
      for (int k = 0; k < BE_W; k++)
        if (wr_be_i[k]) mem_q[wr_idx_i][8*k +: 8] <= wr_data_i[8*k +: 8];
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    word_t raw;
    assign raw = ({1'b0, rd_idx_i[p]} < DEPTH_L) ? mem_q[rd_idx_i[p]] : '0;
    rf_fwd #(.IDX_W(IDX_W)) u_fwd (
      .raw_i    (raw),
      .rd_idx_i (rd_idx_i[p]),
      .wr_hit_i (wr_hit),
      .wr_idx_i (wr_idx_i),
      .wr_data_i(wr_data_i),
      .wr_be_i  (wr_be_i),
      .data_o   (rd_data_o[p])
    );
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 127,
  parameter int RD_PORTS = 2,
  parameter int IDX_W    = $clog2((NUM_REGS + 1) / 2)
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic [NUM_BANKS-1:0][RD_PORTS-1:0][IDX_W-1:0] rd_idx_i,
  output logic [NUM_BANKS-1:0][RD_PORTS-1:0][WORD_W-1:0] rd_data_o,
  input  logic [NUM_BANKS-1:0]                      wr_en_i,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0]           wr_idx_i,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0]          wr_data_i,
  input  logic [NUM_BANKS-1:0][BE_W-1:0]            wr_be_i
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int DEP = bank_depth(NUM_REGS, b);
    rf_bank #(.DEPTH(DEP), .IDX_W(IDX_W), .RD_PORTS(RD_PORTS)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_idx_i (rd_idx_i[b]),
      .rd_data_o(rd_data_o[b]),
      .wr_en_i  (wr_en_i[b]),
      .wr_idx_i (wr_idx_i[b]),
      .wr_data_i(wr_data_i[b]),
      .wr_be_i  (wr_be_i[b])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int NUM_REGS = 127,
  parameter int RD_PORTS = 2,
  parameter int IDX_W    = $clog2((NUM_REGS + 1) / 2)
) (
  input logic                                          clk_i,
  input logic                                          rst_ni,
  input logic [NUM_BANKS-1:0][RD_PORTS-1:0][IDX_W-1:0] rd_idx_i,
  input logic [NUM_BANKS-1:0][RD_PORTS-1:0][WORD_W-1:0] rd_data_o,
  input logic [NUM_BANKS-1:0]                          wr_en_i,
  input logic [NUM_BANKS-1:0][IDX_W-1:0]               wr_idx_i,
  input logic [NUM_BANKS-1:0][WORD_W-1:0]              wr_data_i,
  input logic [NUM_BANKS-1:0][BE_W-1:0]                wr_be_i
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    localparam int DEP = bank_depth(NUM_REGS, b);
    localparam logic [IDX_W:0] DEP_L = DEP[IDX_W:0];
    logic in_rng;
    assign in_rng = {1'b0, wr_idx_i[b]} < DEP_L;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_p
      // R6: full-word write to the read index is bypassed in the same cycle
      assert_fwd_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i[b] && in_rng && wr_be_i[b] == '1 && rd_idx_i[b][p] == wr_idx_i[b])
        |-> rd_data_o[b][p] == wr_data_i[b]);

      // R3: full-word write is held in storage afterwards
      assert_store_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i[b] && in_rng && wr_be_i[b] == '1)
        |=> (wr_en_i[b] || rd_idx_i[b][p] != $past(wr_idx_i[b])
             || rd_data_o[b][p] == $past(wr_data_i[b])));

      // R7: no write enable, same index -> same data
      assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i[b]) ##1 (!wr_en_i[b] && $stable(rd_idx_i[b][p]))
        |-> $stable(rd_data_o[b][p]));

      // R8: index outside the bank reads zero
      assert_oob_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ({1'b0, rd_idx_i[b][p]} >= DEP_L) |-> rd_data_o[b][p] == '0);
    end
  end
endmodule

bind banked_regfile rf_checker #(
  .NUM_REGS(NUM_REGS), .RD_PORTS(RD_PORTS), .IDX_W(IDX_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_idx_i (rd_idx_i),
  .rd_data_o(rd_data_o),
  .wr_en_i  (wr_en_i),
  .wr_idx_i (wr_idx_i),
  .wr_data_i(wr_data_i),
  .wr_be_i  (wr_be_i)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  localparam int NB = 4;
  localparam int NP = 2;
  localparam int IW = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NB-1:0][NP-1:0][IW-1:0] rd_idx;
  logic [NB-1:0][NP-1:0][31:0]   rd_data;
  logic [NB-1:0]                 wr_en;
  logic [NB-1:0][IW-1:0]         wr_idx;
  logic [NB-1:0][31:0]           wr_data;
  logic [NB-1:0][3:0]            wr_be;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] mdl [NB][64];

  always #5 clk_i = ~clk_i;

  banked_regfile u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_be_i(wr_be)
  );

  function automatic int depth_of(int b);
    return (b >= 2) ? 63 : 64;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(int b, int p);
    int i = int'(rd_idx[b][p]);
    logic [31:0] v;
    if (i >= depth_of(b)) return 32'h0;
    v = mdl[b][i];
    if (wr_en[b] && int'(wr_idx[b]) == i) v = merge(v, wr_data[b], wr_be[b]);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = '0; wr_be = '0;
    for (int b = 0; b < NB; b++) begin
      wr_idx[b] = IW'($urandom); wr_data[b] = $urandom;
    end
  endtask

  // inputs already driven after a falling edge: check, clock, update model
  task automatic step(string ovr);
    string tag;
    #1;
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) begin
        if (ovr != "") tag = ovr;
        else if (int'(rd_idx[b][p]) >= depth_of(b)) tag = "R8";
        else if (rd_idx[b][p] == wr_idx[b] && wr_be[b] != 0) tag = wr_en[b] ? "R6" : "R7";
        else tag = "R5";
        chk(tag, rd_data[b][p], exp_rd(b, p));
      end
    @(posedge clk_i);
    for (int b = 0; b < NB; b++)
      if (wr_en[b] && int'(wr_idx[b]) < depth_of(b))
        mdl[b][wr_idx[b]] = merge(mdl[b][wr_idx[b]], wr_data[b], wr_be[b]);
    @(negedge clk_i);
  endtask

  task automatic rd_all(int i);
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < NP; p++) rd_idx[b][p] = IW'(i);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 64; i++) mdl[b][i] = '0;
    idle(); rd_all(0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: every entry zero after reset
    for (int i = 0; i < 64; i++) begin
      idle(); rd_all(i); step("R1");
    end

    // R2 R4: register 10 (even, idx 5) and register 7 (odd, idx 3) written in one cycle
    wr_en = 4'hF; wr_be = {4{4'hF}};
    wr_idx[0] = 6'd5; wr_idx[1] = 6'd5; wr_idx[2] = 6'd3; wr_idx[3] = 6'd3;
    wr_data[0] = 32'h1111_2222; wr_data[1] = 32'h3333_4444;
    wr_data[2] = 32'h5555_6666; wr_data[3] = 32'h7777_8888;
    rd_all(0); step("R4");
    idle();
    rd_idx[0][0] = 6'd5; rd_idx[1][0] = 6'd5; rd_idx[2][1] = 6'd3; rd_idx[3][1] = 6'd3;
    rd_idx[0][1] = 6'd0; rd_idx[1][1] = 6'd0; rd_idx[2][0] = 6'd0; rd_idx[3][0] = 6'd0;
    #1;
    chk("R2", {rd_data[1][0], rd_data[0][0]}  [63:32], 32'h3333_4444);
    chk("R2", {rd_data[1][0], rd_data[0][0]}  [31:0],  32'h1111_2222);
    chk("R4", {rd_data[3][1], rd_data[2][1]}  [63:32], 32'h7777_8888);
    chk("R4", {rd_data[3][1], rd_data[2][1]}  [31:0],  32'h5555_6666);
    chk("R5", rd_data[0][1], 32'h0);
    step("");

    // R3: partial byte write to register 10 low half
    wr_en[0] = 1'b1; wr_idx[0] = 6'd5; wr_be[0] = 4'b0101; wr_data[0] = 32'hAABB_CCDD;
    rd_idx[0][0] = 6'd5; #1;
    chk("R6", rd_data[0][0], 32'h11BB_22DD);
    step("");
    idle(); rd_idx[0][0] = 6'd5; #1;
    chk("R3", rd_data[0][0], 32'h11BB_22DD);
    step("");

    // R7: enables set but write disabled
    wr_en[0] = 1'b0; wr_idx[0] = 6'd5; wr_be[0] = 4'hF; wr_data[0] = 32'hDEAD_BEEF;
    rd_idx[0][1] = 6'd5; #1;
    chk("R7", rd_data[0][1], 32'h11BB_22DD);
    step("");
    idle(); rd_idx[0][1] = 6'd5; #1;
    chk("R7", rd_data[0][1], 32'h11BB_22DD);
    step("");

    // R8: register 127 (odd bank index 63)
    wr_en[3] = 1'b1; wr_idx[3] = 6'd63; wr_be[3] = 4'hF; wr_data[3] = 32'hFFFF_FFFF;
    rd_idx[3][0] = 6'd63; #1;
    chk("R8", rd_data[3][0], 32'h0);
    step("");
    idle(); rd_idx[3][0] = 6'd63; #1;
    chk("R8", rd_data[3][0], 32'h0);
    step("");

    // constrained random with model
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < NB; b++) begin
        wr_en[b]   = ($urandom % 3) != 0;
        wr_idx[b]  = ($urandom % 8 == 0) ? 6'd63 : IW'($urandom % 8);
        wr_data[b] = $urandom;
        wr_be[b]   = 4'($urandom);
        for (int p = 0; p < NP; p++)
          rd_idx[b][p] = ($urandom % 2) ? wr_idx[b] : IW'($urandom % 8);
      end
      step("");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule